// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block drives the frequency-offset word that a clock synthesizer adds to its feedback divider so that the synthesized clock is swept slowly across a narrow band. This lowers the peak of the emitted spectrum. The block does not contain the PLL, the oscillator or the loop filter. It only produces the digital sweep: a signed offset counted in steps of 0.0125% of the nominal frequency. A symmetric triangle rises and falls between two bounds that a 3-bit width code selects.

Bits [2:1] of the width code choose the total sweep depth. Bit 0 chooses where the band lies. When it is clear, the band sits entirely below nominal and touches nominal at its top. When it is set, the band is centred on nominal. An active-low enable gates the modulation: while the enable is high, the offset is zero. A changed width code, or a fresh assertion of the enable, restarts the triangle from zero. A one-cycle strobe marks every cycle in which the offset takes a new value.

The offset and strobe form an output-only stream. The strobe plays the part of a valid flag and there is no ready input. The sweep cannot be stalled, so the consumer must take each new value in the cycle its strobe is high. The enable and the width code are plain level controls.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted, and after it is released with the enable high, `offset` is 0 and `step_stb` is 0.
- R2: The sweep depth D, in 0.0125% units, is BASE_SPAN shifted left by `wsel[2:1]`. With the default BASE_SPAN of 100, the codes 00, 01, 10 and 11 give 100, 200, 400 and 800, which are 1.25%, 2.5%, 5% and 10%.
- R3: With `wsel[0]`=0 (down-spread), the offset sweeps between -D and 0, and its first step after a restart is to -1.
- R4: With `wsel[0]`=1 (centre-spread), the offset sweeps between -D/2 and +D/2, and its first step after a restart is to +1.
- R5: The offset moves by exactly one unit every STEP_DIV clocks and reverses direction at each bound. One full period lasts 2*D*STEP_DIV clocks, so the default STEP_DIV of 5 gives at least 1000 clocks per period at every depth.
- R6: While `spread_en_n` is high, `offset` is 0 from the next cycle on. A change of `wsel` in that time has no effect.
- R7: A restart occurs when `wsel` differs from its value in the previous cycle, or when `spread_en_n` falls. A restart makes `offset` 0 in the next cycle, and the next step follows STEP_DIV clocks later. A restart takes priority over a step due in the same cycle.
- R8: `step_stb` is 1 in exactly those cycles in which `offset` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spread_en_n | input | 1 | Modulation enable, active low |
| wsel | input | 3 | Width code: [2:1] depth, [0] centre (1) or down (0) |
| offset | output | OFS_W | Signed frequency offset, in 0.0125% units |
| step_stb | output | 1 | High for one cycle whenever `offset` changes |

## Verification
A scheduled step and a restart can both fall due in the same cycle. The bench provokes this by switching the width code on the cycle just before the prescaler reaches a step edge, part-way down a deep down-spread sweep. It judges the result by three things: the offset returns to 0 with a strobe instead of taking its next step; it stays at 0 for the following STEP_DIV-1 cycles; and its first move is then +1, the direction of the new centre-spread code.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/ssc_bounds.sv
module ssc_bounds #(
  parameter int OFS_W     = 12,
  parameter int BASE_SPAN = 100
) (
  input  logic [2:0]              wsel,
  output logic signed [OFS_W-1:0] lo,
  output logic signed [OFS_W-1:0] hi,
  output ssc_pkg::dir_e           start_dir
);
  import ssc_pkg::*;
  localparam int NDEPTH = 4;

  logic signed [OFS_W-1:0] depth_tab [NDEPTH];
  logic signed [OFS_W-1:0] depth;

  // one depth per code of wsel[2:1], each doubling the previous
  for (genvar g = 0; g < NDEPTH; g++) begin : g_depth
    assign depth_tab[g] = $signed(OFS_W'(BASE_SPAN << g));
  end

  assign depth = depth_tab[wsel[2:1]];

  always_comb begin
    if (wsel[0]) begin
      hi        = depth >>> 1;
      lo        = -(depth >>> 1);
      start_dir = DIR_UP;
    end else begin
      hi        = '0;
      lo        = -depth;
      start_dir = DIR_DN;
    end
  end
endmodule

// File: rtl/ssc_tick.sv
module ssc_tick #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/ssc_tri_core.sv
module ssc_tri_core #(
  parameter int OFS_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  logic                    restart,
  input  logic                    tick,
  input  logic signed [OFS_W-1:0] lo,
  input  logic signed [OFS_W-1:0] hi,
  input  ssc_pkg::dir_e           start_dir,
  output logic signed [OFS_W-1:0] offset,
  output logic                    stb
);
  import ssc_pkg::*;
  localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

  logic signed [OFS_W-1:0] off_q, off_nxt;
  dir_e                    dir_q, dir_nxt;
  logic                    stb_q;

  always_comb begin
    off_nxt = off_q;
    dir_nxt = dir_q;
    if (hold || restart) begin
      off_nxt = '0;
      dir_nxt = start_dir;
    end else if (tick) begin
      if (dir_q == DIR_UP) begin
        if (off_q >= hi) begin
          dir_nxt = DIR_DN;
          off_nxt = off_q - ONE;
        end else begin
          off_nxt = off_q + ONE;
        end
      end else begin
        if (off_q <= lo) begin
          dir_nxt = DIR_UP;
          off_nxt = off_q + ONE;
        end else begin
          off_nxt = off_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      dir_q <= DIR_DN;
      stb_q <= 1'b0;
    end else begin
      off_q <= off_nxt;
      dir_q <= dir_nxt;
      stb_q <= (off_nxt != off_q);
    end
  end

  assign offset = off_q;
  assign stb    = stb_q;
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int OFS_W     = 12,
  parameter int BASE_SPAN = 100,
  parameter int STEP_DIV  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spread_en_n,
  input  logic [2:0]              wsel,
  output logic signed [OFS_W-1:0] offset,
  output logic                    step_stb
);
  import ssc_pkg::*;

  logic                    active, active_q;
  logic [2:0]              wsel_q;
  logic                    restart, tick;
  logic signed [OFS_W-1:0] lo, hi;
  dir_e                    start_dir;

  assign active  = !spread_en_n;
  assign restart = active && (!active_q || (wsel != wsel_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wsel_q   <= '0;
    end else begin
      active_q <= active;
      wsel_q   <= wsel;
    end
  end

  ssc_bounds #(.OFS_W(OFS_W), .BASE_SPAN(BASE_SPAN)) u_bounds (
    .wsel(wsel), .lo(lo), .hi(hi), .start_dir(start_dir)
  );

  ssc_tick #(.DIV(STEP_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(!active || restart), .tick(tick)
  );

  ssc_tri_core #(.OFS_W(OFS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .hold(!active), .restart(restart), .tick(tick),
    .lo(lo), .hi(hi), .start_dir(start_dir), .offset(offset), .stb(step_stb)
  );
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int OFS_W     = 12,
  parameter int BASE_SPAN = 100
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    spread_en_n,
  input logic [2:0]              wsel,
  input logic signed [OFS_W-1:0] offset,
  input logic                    step_stb
);
  function automatic int span(input logic [1:0] c);
    return BASE_SPAN << c;
  endfunction

  // R8: strobe marks exactly the cycles with a new offset
  a_r8_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb == (offset != $past(offset)));

  // R5: every nonzero new value is one unit from the last
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && offset != 0) |->
      ((int'(offset) - int'($past(offset)) == 1) || (int'(offset) - int'($past(offset)) == -1)));

  // R6: disabled modulation gives zero offset next cycle
  a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en_n |=> offset == 0);

  // R7: fresh enable restarts at zero
  a_r7_enable_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!spread_en_n && $past(spread_en_n)) |=> offset == 0);

  // R7: code change restarts at zero
  a_r7_code_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel != $past(wsel)) |=> offset == 0);

  // R3: down-spread band
  a_r3_down_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wsel[0]) |-> (int'(offset) <= 0 && int'(offset) >= -span($past(wsel[2:1]))));

  // R4: centre-spread band
  a_r4_centre_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wsel[0]) |->
      (int'(offset) <= span($past(wsel[2:1])) / 2 && int'(offset) >= -(span($past(wsel[2:1])) / 2)));
endmodule

bind ssc_profile_gen ssc_profile_chk #(.OFS_W(OFS_W), .BASE_SPAN(BASE_SPAN)) u_chk (.*);

// File: tb/sim_ssc_profile_gen.sv
module sim_ssc_profile_gen;
  localparam int OFS_W = 12;
  localparam int BASE  = 100;
  localparam int N     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spread_en_n = 1'b1;
  logic [2:0] wsel = 3'b000;
  logic signed [OFS_W-1:0] offset;
  logic step_stb;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ssc_profile_gen #(.OFS_W(OFS_W), .BASE_SPAN(BASE), .STEP_DIV(N)) u0 (
    .clk(clk), .rst_n(rst_n), .spread_en_n(spread_en_n), .wsel(wsel),
    .offset(offset), .step_stb(step_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(offset == 0, "R1 offset in reset", int'(offset), 0);
    chk(step_stb == 0, "R1 strobe in reset", int'(step_stb), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(offset == 0, "R1 offset after release, disabled", int'(offset), 0);
    chk(step_stb == 0, "R1 strobe after release, disabled", int'(step_stb), 0);
  endtask

  // R2..R5, R8: one full sweep for a width code
  task automatic t_sweep(input logic [2:0] code);
    int d, elo, ehi, efirst, mn, mx, nstb, perc, first, badstep, badstb, prev, cur;
    d      = BASE << code[2:1];
    elo    = code[0] ? -(d / 2) : -d;
    ehi    = code[0] ? d / 2 : 0;
    efirst = code[0] ? 1 : -1;
    @(negedge clk);
    spread_en_n = 1'b1;
    repeat (2) @(negedge clk);
    wsel = code;
    spread_en_n = 1'b0;
    @(negedge clk);
    chk(offset == 0, "R7 zero after enable", int'(offset), 0);
    mn = 0; mx = 0; nstb = 0; perc = -1; first = 0; badstep = 0; badstb = 0; prev = 0;
    for (int c = 1; c <= 2 * d * N + N; c++) begin
      @(negedge clk);
      cur = int'(offset);
      if (step_stb != (cur != prev)) badstb++;
      if (step_stb) begin
        nstb++;
        if (cur - prev != 1 && cur - prev != -1) badstep++;
        if (nstb == 2 * d && perc < 0) perc = c;
      end
      if (c == N) first = cur;
      if (cur < mn) mn = cur;
      if (cur > mx) mx = cur;
      prev = cur;
    end
    chk(mn == elo, code[0] ? "R2/R4 minimum" : "R2/R3 minimum", mn, elo);
    chk(mx == ehi, code[0] ? "R2/R4 maximum" : "R2/R3 maximum", mx, ehi);
    chk(first == efirst, code[0] ? "R4 first step" : "R3 first step", first, efirst);
    chk(perc == 2 * d * N, "R5 period in clocks", perc, 2 * d * N);
    chk(badstep == 0, "R5 unit steps", badstep, 0);
    chk(badstb == 0, "R8 strobe matches change", badstb, 0);
  endtask

  // R6: disable clears and ignores the code
  task automatic t_disable();
    int bad;
    @(negedge clk);
    spread_en_n = 1'b1;
    repeat (2) @(negedge clk);
    wsel = 3'b010;
    spread_en_n = 1'b0;
    repeat (7 * N + 1) @(negedge clk);
    chk(offset == -7, "R3 mid-sweep before disable", int'(offset), -7);
    spread_en_n = 1'b1;
    @(negedge clk);
    chk(offset == 0, "R6 zero after disable", int'(offset), 0);
    chk(step_stb == 1, "R8 strobe on return to zero", int'(step_stb), 1);
    bad = 0;
    for (int c = 0; c < 60; c++) begin
      if (c % 7 == 0) wsel = 3'(c / 7);
      @(negedge clk);
      if (offset != 0 || step_stb) bad++;
    end
    chk(bad == 0, "R6 held at zero, code ignored", bad, 0);
  endtask

  // R7: restart and step in the same cycle
  task automatic t_coincide();
    @(negedge clk);
    spread_en_n = 1'b1;
    repeat (2) @(negedge clk);
    wsel = 3'b110;
    spread_en_n = 1'b0;
    @(negedge clk);
    repeat (3 * N - 1) @(negedge clk);
    chk(offset == -2, "R5 offset before coincident edge", int'(offset), -2);
    wsel = 3'b011;
    @(negedge clk);
    chk(offset == 0, "R7 restart beats step", int'(offset), 0);
    chk(step_stb == 1, "R8 strobe on restart", int'(step_stb), 1);
    repeat (N - 1) @(negedge clk);
    chk(offset == 0, "R7 no step before STEP_DIV clocks", int'(offset), 0);
    @(negedge clk);
    chk(offset == 1, "R7 first step after restart", int'(offset), 1);
  endtask

  initial begin
    t_reset();
    for (int k = 0; k < 8; k++) t_sweep(3'(k));
    t_disable();
    t_coincide();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule